// File: doc/BRIEF.md
# Timestamped Event Order Guard

This block screens a stream of timestamped output events before they reach a per-channel scheduler. Each event names a channel and carries a timestamp. The low bits of the timestamp give a position inside one system-clock cycle (the fine part). The remaining upper bits count whole system-clock cycles (the coarse part). For each channel the guard keeps the timestamp of the last event it let through. A new event passes only if its time is strictly later than that stored time and it does not ask for a second sub-cycle position inside a coarse cycle that is already in use.

An event can be dropped for one of three reasons. It may run backwards in time. It may collide with the previous event inside one coarse cycle. Or it may arrive while the scheduler still reports that channel as busy. A busy drop is not flagged when it happens; it is flagged when the next event for the same channel comes in. Each kind of error has a sticky flag that records the channel of the first offender and holds it until software clears it. The guard keeps running after any error.

Top module: `tsq_order_guard`

## Requirements
- R1: An event presented with `ev_valid` is sampled on a rising clock edge. If it is accepted, `acc_valid` goes high for one cycle after the following edge, with `acc_chan` and `acc_ts` set to the event's channel and timestamp.
- R2: An event whose timestamp is less than or equal to the stored last timestamp of its channel is dropped and sets `seq_err`, with `seq_chan` set to its channel.
- R3: The coarse part is `ev_ts[63:3]` and the fine part is `ev_ts[2:0]` (ratio 8). An event with the same coarse part as the stored timestamp but a different fine part is dropped and sets `col_err`, with `col_chan` set to its channel. This check takes priority over R2, so in that case `seq_err` is not set.
- R4: An accepted event replaces its channel's stored timestamp. A dropped event leaves the stored timestamp unchanged, and later valid events are still accepted.
- R5: Each channel has its own stored timestamp, and all of them are zero after reset. So a first event at time 0 raises a sequence error, and a first event with coarse 0 and a nonzero fine part raises a collision error.
- R6: An event whose channel has its `chan_busy` bit high is dropped without any timestamp check, and no flag is raised at that time. The next event on that channel sets `busy_err`, with `busy_chan` set to the channel, and that next event is itself judged normally. Busy bits of other channels have no effect.
- R7: Each error flag is sticky and keeps the channel of the first offender until `err_clr` is pulsed. If a new error arrives in the same cycle as `err_clr`, the flag stays set and holds the new channel.
- R8: Events for the same channel on consecutive cycles are each judged against the result of the one before.
- R9: After reset, `acc_valid` and all three error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_chan | input | CH_W (2) | Event channel |
| ev_ts | input | TS_W (64) | Event timestamp, coarse above fine |
| chan_busy | input | NCH (4) | Per-channel busy indication from the scheduler |
| err_clr | input | 1 | Clears all sticky error flags |
| acc_valid | output | 1 | Accepted event strobe |
| acc_chan | output | CH_W (2) | Channel of accepted event |
| acc_ts | output | TS_W (64) | Timestamp of accepted event |
| seq_err | output | 1 | Sticky ordering error |
| seq_chan | output | CH_W (2) | Channel of first ordering error |
| col_err | output | 1 | Sticky same-cycle collision error |
| col_chan | output | CH_W (2) | Channel of first collision error |
| busy_err | output | 1 | Sticky late busy report |
| busy_chan | output | CH_W (2) | Channel of first busy report |

## Verification
The bench builds the guard with its defaults: four channels, a 64-bit timestamp and a ratio of 8, which gives three fine bits. With four channels the bench can keep one channel at a high timestamp while it checks independence, reset-zero behaviour and busy isolation on the others. Three fine bits let small hand-picked timestamps fall on either side of a coarse boundary, so collision and ordering errors can be told apart directly. Back-to-back events on one channel exercise the path where a timestamp written in one cycle must be seen by the compare in the next.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic [1:0] {
    VERD_OK   = 2'd0,
    VERD_SEQ  = 2'd1,
    VERD_COL  = 2'd2,
    VERD_BUSY = 2'd3
  } verdict_t;

  localparam int N_ERR   = 3;
  localparam int ERR_SEQ = 0;
  localparam int ERR_COL = 1;
  localparam int ERR_BSY = 2;
endpackage

// File: rtl/tsq_last_store.sv
// Per-channel last-accepted timestamp storage. The array has no reset so it
// can map onto block RAM; a separate written-bit vector makes unwritten
// entries read as zero. A one-entry bypass covers a write and a read of the
// same address on the same edge.
module tsq_last_store #(
  parameter int TS_W = 64,
  parameter int AW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   raddr,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [TS_W-1:0] wdata,
  output logic [TS_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [TS_W-1:0] mem [DEPTH];
  logic [TS_W-1:0] mem_q;
  logic [DEPTH-1:0] written;
  logic            written_q;
  logic            byp_hit;
  logic [TS_W-1:0] byp_data;
  logic            same_addr;

  assign same_addr = we && (waddr == raddr);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written   <= '0;
      written_q <= 1'b0;
      byp_hit   <= 1'b0;
      byp_data  <= '0;
    end else begin
      if (we) written[waddr] <= 1'b1;
      written_q <= written[raddr];
      byp_hit   <= same_addr;
      byp_data  <= wdata;
    end
  end

  assign rdata = byp_hit   ? byp_data :
                 written_q ? mem_q    : '0;
endmodule

// File: rtl/tsq_judge.sv
module tsq_judge
  import tsq_pkg::*;
#(
  parameter int TS_W   = 64,
  parameter int FINE_W = 3
) (
  input  logic [TS_W-1:0] ts,
  input  logic [TS_W-1:0] last,
  input  logic            busy,
  output verdict_t        verdict
);
  logic collide;
  logic behind;

  generate
    if (FINE_W > 0) begin : g_fine
      assign collide = (ts[TS_W-1:FINE_W] == last[TS_W-1:FINE_W]) &&
                       (ts[FINE_W-1:0] != last[FINE_W-1:0]);
    end else begin : g_nofine
      assign collide = 1'b0;
    end
  endgenerate

  assign behind = (ts <= last);

  always_comb begin
    if (busy)         verdict = VERD_BUSY;
    else if (collide) verdict = VERD_COL;
    else if (behind)  verdict = VERD_SEQ;
    else              verdict = VERD_OK;
  end
endmodule

// File: rtl/tsq_err_flag.sv
module tsq_err_flag #(
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            hit,
  input  logic [CH_W-1:0] hit_chan,
  output logic            flag,
  output logic [CH_W-1:0] chan
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      chan <= '0;
    end else if (hit && (!flag || clr)) begin
      flag <= 1'b1;
      chan <= hit_chan;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tsq_order_guard.sv
module tsq_order_guard
  import tsq_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int TS_W       = 64,
  parameter int FINE_RATIO = 8,
  localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_valid,
  input  logic [CH_W-1:0] ev_chan,
  input  logic [TS_W-1:0] ev_ts,
  input  logic [NCH-1:0]  chan_busy,
  input  logic            err_clr,
  output logic            acc_valid,
  output logic [CH_W-1:0] acc_chan,
  output logic [TS_W-1:0] acc_ts,
  output logic            seq_err,
  output logic [CH_W-1:0] seq_chan,
  output logic            col_err,
  output logic [CH_W-1:0] col_chan,
  output logic            busy_err,
  output logic [CH_W-1:0] busy_chan
);
  localparam int FINE_W = (FINE_RATIO > 1) ? $clog2(FINE_RATIO) : 0;
  localparam int DEPTH  = 1 << CH_W;

  logic [DEPTH-1:0] busy_ext;
  assign busy_ext = DEPTH'(chan_busy);

  // stage 1: event registered while its stored timestamp is read
  logic            s1_valid;
  logic [CH_W-1:0] s1_chan;
  logic [TS_W-1:0] s1_ts;
  logic            s1_busy;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= ev_valid;
    s1_chan <= ev_chan;
    s1_ts   <= ev_ts;
    s1_busy <= busy_ext[ev_chan];
  end

  logic [TS_W-1:0] last_ts;
  verdict_t        verdict;
  logic            accept;

  assign accept = s1_valid && (verdict == VERD_OK);

  tsq_last_store #(.TS_W(TS_W), .AW(CH_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .raddr (ev_chan),
    .we    (accept),
    .waddr (s1_chan),
    .wdata (s1_ts),
    .rdata (last_ts)
  );

  tsq_judge #(.TS_W(TS_W), .FINE_W(FINE_W)) u_judge (
    .ts      (s1_ts),
    .last    (last_ts),
    .busy    (s1_busy),
    .verdict (verdict)
  );

  // busy drops are remembered per channel and reported by the next event
  logic [DEPTH-1:0] pend_busy;
  always_ff @(posedge clk) begin
    if (rst)           pend_busy <= '0;
    else if (s1_valid) pend_busy[s1_chan] <= s1_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      acc_chan  <= '0;
      acc_ts    <= '0;
    end else begin
      acc_valid <= accept;
      acc_chan  <= s1_chan;
      acc_ts    <= s1_ts;
    end
  end

  logic [N_ERR-1:0] err_hit;
  logic [N_ERR-1:0] err_flag;
  logic [CH_W-1:0]  err_chan [N_ERR];

  assign err_hit[ERR_SEQ] = s1_valid && (verdict == VERD_SEQ);
  assign err_hit[ERR_COL] = s1_valid && (verdict == VERD_COL);
  assign err_hit[ERR_BSY] = s1_valid && pend_busy[s1_chan];

  generate
    for (genvar g = 0; g < N_ERR; g++) begin : g_flag
      tsq_err_flag #(.CH_W(CH_W)) u_flag (
        .clk      (clk),
        .rst      (rst),
        .clr      (err_clr),
        .hit      (err_hit[g]),
        .hit_chan (s1_chan),
        .flag     (err_flag[g]),
        .chan     (err_chan[g])
      );
    end
  endgenerate

  assign seq_err   = err_flag[ERR_SEQ];
  assign seq_chan  = err_chan[ERR_SEQ];
  assign col_err   = err_flag[ERR_COL];
  assign col_chan  = err_chan[ERR_COL];
  assign busy_err  = err_flag[ERR_BSY];
  assign busy_chan = err_chan[ERR_BSY];
endmodule

// File: rtl/tsq_order_guard_props.sv
module tsq_order_guard_props #(
  parameter int NCH  = 4,
  parameter int TS_W = 64,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            ev_valid,
  input logic [CH_W-1:0] ev_chan,
  input logic [NCH-1:0]  chan_busy,
  input logic            err_clr,
  input logic            acc_valid,
  input logic [CH_W-1:0] acc_chan,
  input logic [TS_W-1:0] acc_ts,
  input logic            seq_err,
  input logic [CH_W-1:0] seq_chan,
  input logic            col_err,
  input logic [CH_W-1:0] col_chan
);
  logic busy_sel;
  assign busy_sel = (int'(ev_chan) < NCH) ? chan_busy[ev_chan] : 1'b0;

  a_r1_acc_from_event: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $past(ev_valid, 2));

  a_r1_acc_chan_match: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> (acc_chan == $past(ev_chan, 2)));

  a_r4_acc_ts_rises: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && $past(acc_valid) && (acc_chan == $past(acc_chan)))
      |-> (acc_ts > $past(acc_ts)));

  a_r2_seq_needs_event: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_err) |-> $past(ev_valid, 2));

  a_r6_busy_drops: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && busy_sel) |-> ##2 !acc_valid);

  a_r7_seq_sticky: assert property (@(posedge clk) disable iff (rst)
    (seq_err && !err_clr) |=> (seq_err && $stable(seq_chan)));

  a_r7_col_sticky: assert property (@(posedge clk) disable iff (rst)
    (col_err && !err_clr) |=> (col_err && $stable(col_chan)));
endmodule

bind tsq_order_guard tsq_order_guard_props #(.NCH(NCH), .TS_W(TS_W)) u_props (
  .clk       (clk),
  .rst       (rst),
  .ev_valid  (ev_valid),
  .ev_chan   (ev_chan),
  .chan_busy (chan_busy),
  .err_clr   (err_clr),
  .acc_valid (acc_valid),
  .acc_chan  (acc_chan),
  .acc_ts    (acc_ts),
  .seq_err   (seq_err),
  .seq_chan  (seq_chan),
  .col_err   (col_err),
  .col_chan  (col_chan)
);

// File: tb/tsq_order_guard_bench.sv
`timescale 1ns/1ps
module tsq_order_guard_bench;
  localparam int NCH  = 4;
  localparam int TS_W = 64;
  localparam int CH_W = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ev_valid = 1'b0;
  logic [CH_W-1:0] ev_chan = '0;
  logic [TS_W-1:0] ev_ts = '0;
  logic [NCH-1:0]  chan_busy = '0;
  logic            err_clr = 1'b0;
  logic            acc_valid;
  logic [CH_W-1:0] acc_chan;
  logic [TS_W-1:0] acc_ts;
  logic            seq_err, col_err, busy_err;
  logic [CH_W-1:0] seq_chan, col_chan, busy_chan;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tsq_order_guard #(.NCH(NCH), .TS_W(TS_W), .FINE_RATIO(8)) u_tsq_order_guard (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_chan(ev_chan), .ev_ts(ev_ts),
    .chan_busy(chan_busy), .err_clr(err_clr), .acc_valid(acc_valid),
    .acc_chan(acc_chan), .acc_ts(acc_ts), .seq_err(seq_err), .seq_chan(seq_chan),
    .col_err(col_err), .col_chan(col_chan), .busy_err(busy_err), .busy_chan(busy_chan)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_acc(input bit exp, input logic [63:0] ts, input string req);
    check(acc_valid == exp, req, 64'(acc_valid), 64'(exp));
    if (exp) check(acc_ts == ts, req, acc_ts, ts);
  endtask

  // returns at the falling edge after the result is registered
  task automatic send(input int ch, input logic [63:0] ts, input logic [NCH-1:0] bsy);
    @(negedge clk);
    ev_valid = 1'b1; ev_chan = CH_W'(ch); ev_ts = ts; chan_busy = bsy;
    @(negedge clk);
    ev_valid = 1'b0; chan_busy = '0;
    @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic t_reset();
    check(acc_valid == 1'b0, "R9 acc_valid", 64'(acc_valid), 0);
    check({seq_err, col_err, busy_err} == 3'b000, "R9 flags",
          64'({seq_err, col_err, busy_err}), 0);
  endtask

  task automatic t_accept();
    send(0, 64'h10, '0);
    expect_acc(1, 64'h10, "R1 first");
    check(acc_chan == 0, "R1 chan", 64'(acc_chan), 0);
    send(0, 64'h25, '0);
    expect_acc(1, 64'h25, "R1 later");
  endtask

  task automatic t_sequence();
    send(0, 64'h18, '0);
    expect_acc(0, 0, "R2 backwards");
    check(seq_err && seq_chan == 0, "R2 flag", 64'(seq_err), 1);
    clear_flags();
    check(!seq_err, "R7 clear", 64'(seq_err), 0);
    send(0, 64'h25, '0);
    expect_acc(0, 0, "R2 equal");
    check(seq_err, "R2 equal flag", 64'(seq_err), 1);
    clear_flags();
  endtask

  task automatic t_collision();
    send(0, 64'h22, '0);
    expect_acc(0, 0, "R3 earlier fine");
    check(col_err && col_chan == 0, "R3 flag", 64'(col_err), 1);
    check(!seq_err, "R3 priority", 64'(seq_err), 0);
    clear_flags();
    send(0, 64'h27, '0);
    expect_acc(0, 0, "R3 later fine");
    check(col_err, "R3 later flag", 64'(col_err), 1);
    clear_flags();
  endtask

  task automatic t_unchanged();
    send(0, 64'h30, '0);
    expect_acc(1, 64'h30, "R4 runs on");
    send(0, 64'h28, '0);
    expect_acc(0, 0, "R4 drop");
    send(0, 64'h29, '0);
    expect_acc(0, 0, "R4 last kept");
    check(seq_err, "R4 flag", 64'(seq_err), 1);
    clear_flags();
    send(0, 64'h38, '0);
    expect_acc(1, 64'h38, "R4 recover");
  endtask

  task automatic t_channels();
    send(1, 64'h8, '0);
    expect_acc(1, 64'h8, "R5 independent");
    send(2, 64'h0, '0);
    expect_acc(0, 0, "R5 zero ts");
    check(seq_err && seq_chan == 2, "R5 seq chan", 64'(seq_chan), 2);
    clear_flags();
    send(3, 64'h3, '0);
    expect_acc(0, 0, "R5 coarse zero");
    check(col_err && col_chan == 3, "R5 col chan", 64'(col_chan), 3);
    send(1, 64'h9, '0);
    check(col_err && col_chan == 3, "R7 first kept", 64'(col_chan), 3);
    clear_flags();
    check(!col_err, "R7 cleared", 64'(col_err), 0);
    @(negedge clk);
    ev_valid = 1'b1; ev_chan = 2'd1; ev_ts = 64'hA;
    @(negedge clk);
    ev_valid = 1'b0; err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    check(col_err && col_chan == 1, "R7 clear with hit", 64'(col_chan), 1);
    clear_flags();
  endtask

  task automatic t_busy();
    send(1, 64'h40, 4'b0010);
    expect_acc(0, 0, "R6 busy drop");
    check({seq_err, col_err, busy_err} == 3'b000, "R6 no flag yet",
          64'({seq_err, col_err, busy_err}), 0);
    send(1, 64'h50, '0);
    expect_acc(1, 64'h50, "R6 next judged");
    check(busy_err && busy_chan == 1, "R6 late report", 64'(busy_chan), 1);
    clear_flags();
    send(2, 64'h60, 4'b0010);
    expect_acc(1, 64'h60, "R6 other channel");
    send(1, 64'h58, '0);
    expect_acc(1, 64'h58, "R6 single report acc");
    check(!busy_err, "R6 single report", 64'(busy_err), 0);
  endtask

  task automatic pair(input int ch, input logic [63:0] a, input logic [63:0] b,
                      input bit exp_b, input string req);
    @(negedge clk);
    ev_valid = 1'b1; ev_chan = CH_W'(ch); ev_ts = a;
    @(negedge clk);
    ev_ts = b;
    @(negedge clk);
    ev_valid = 1'b0;
    expect_acc(1, a, req);
    @(negedge clk);
    expect_acc(exp_b, b, req);
  endtask

  task automatic t_back_to_back();
    pair(2, 64'h100, 64'h108, 1, "R8 both pass");
    pair(2, 64'h200, 64'h1F8, 0, "R8 second behind");
    check(seq_err && seq_chan == 2, "R8 seq flag", 64'(seq_chan), 2);
    clear_flags();
    pair(3, 64'h400, 64'h403, 0, "R8 second collides");
    check(col_err && col_chan == 3, "R8 col flag", 64'(col_chan), 3);
    clear_flags();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_accept();
    t_sequence();
    t_collision();
    t_unchanged();
    t_channels();
    t_busy();
    t_back_to_back();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule